// File: doc/BRIEF.md
# Cascadable Synchronous BCD Decade Counter

This block is a single decimal digit counter. On each rising clock edge it advances through the binary-coded-decimal values 0 to 9 and then wraps to 0, so its modulus is ten. A synchronous parallel load puts an arbitrary 4-bit value into the digit. This makes the block usable as a programmable divider: reload a start value each time the count reaches its end.

Counting needs two enables to be high at once. One of them, the carry-chain enable, also gates the carry-out flag. That flag is combinational and is high when the digit shows 9 while the carry-chain enable is high. Chaining several digits is therefore simple: tie every stage to the same clock and feed each carry-out into the next stage's carry-chain enable. Every digit then changes on the same edge, with no ripple between clocks.

A parameter selects one of two reset styles. With the asynchronous style, a low reset clears the digit at once. With the synchronous style, the digit is cleared on the next rising edge.

Top module: `bcd_decade_stage`

## Requirements
- R1: With reset inactive, `load_n` high and both `cnt_en` and `carry_en` high, each rising edge moves `q` from v to v+1 for v in 0..8, and from 9 to 0.
- R2: When `load_n` is low (active-low) and reset is inactive, the rising edge copies `din` into `q`, whatever the values of both enables.
- R3: When `load_n` is high and either enable is low, `q` keeps its value across the edge.
- R4: `carry_out` is high exactly when `q` equals 9 and `carry_en` is high, within the same cycle. `cnt_en` has no effect on it.
- R5: With `ASYNC_CLEAR`=1, a low `rst_n` forces `q` to 0 at once, with no clock edge, and holds it there against load and count.
- R6: With `ASYNC_CLEAR`=0, a low `rst_n` leaves `q` unchanged until the next rising edge and then sets it to 0, taking priority over load and count.
- R7: A non-decimal value left in the digit by a load returns to the decimal sequence while counting, using these next states: 10→11, 11→6, 12→13, 13→4, 14→15, 15→2.
- R8: Three stages chained through `carry_out` → `carry_en`, with `cnt_en` high on every stage, count 000 to 999 and wrap to 000. The middle carry is high for exactly one sampled cycle in each hundred, and the top carry for exactly one in each thousand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low clear; asynchronous or synchronous per `ASYNC_CLEAR` |
| load_n | input | 1 | Active-low synchronous parallel load |
| cnt_en | input | 1 | Count enable that gates counting only |
| carry_en | input | 1 | Count enable that also gates `carry_out` |
| din | input | 4 | Value to load |
| q | output | 4 | Current digit |
| carry_out | output | 1 | Terminal-count flag for the next stage |

## Verification
The hardest states to reach from the ports are the ones the counter never enters while counting normally: the six non-decimal codes. The stimulus reaches each one by loading it directly, then releases the load with both enables high, so the scoreboard sees the single recovery step. The code 15 is followed for two more steps, to show it rejoins the decimal sequence. A second hard case is a carry that must be high only in the cycles where every lower digit is 9. That case is reached by running a three-stage chain through its full thousand-state cycle while the bench counts the sampled cycles in which each carry is high.

// File: rtl/bcd_stage_pkg.sv
// Package: shared constants, types and the decade step function for the
// BCD digit stage. Assumes a 4-bit digit in the 8421 code.
package bcd_stage_pkg;

    localparam int DIGIT_W  = 4;
    localparam int MODULUS  = 10;
    localparam logic [DIGIT_W-1:0] LAST_DIGIT = DIGIT_W'(MODULUS - 1);

    typedef logic [DIGIT_W-1:0] digit_t;

    // Operation chosen for the coming edge (reset is handled by the register).
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2
    } stage_op_e;

    // Next digit when counting; non-decimal codes fold back toward 0..9.
    function automatic digit_t decade_step(input digit_t cur);
        digit_t nxt;
        case (cur)
            LAST_DIGIT: nxt = '0;
            4'd11:      nxt = 4'd6;
            4'd13:      nxt = 4'd4;
            4'd15:      nxt = 4'd2;
            default:    nxt = cur + digit_t'(1);
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/bcd_op_select.sv
// Module: picks the operation for the next edge from the load and the two
// enables. Load wins over counting; counting needs both enables.
// Assumes reset priority is applied downstream in the state register.
module bcd_op_select
    import bcd_stage_pkg::*;
(
    input  logic      load_n,
    input  logic      cnt_en,
    input  logic      carry_en,
    output stage_op_e op
);

    // Priority encode: load, then count, else hold.
    always_comb begin
        if (!load_n)
            op = OP_LOAD;
        else if (cnt_en && carry_en)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/bcd_next_value.sv
// Module: forms the value the digit takes on the next edge for the chosen
// operation. Pure combinational; assumes op is already prioritised.
module bcd_next_value
    import bcd_stage_pkg::*;
(
    input  stage_op_e op,
    input  digit_t    cur,
    input  digit_t    din,
    output digit_t    nxt
);

    // Select among hold, load and decade step.
    always_comb begin
        unique case (op)
            OP_LOAD:  nxt = din;
            OP_COUNT: nxt = decade_step(cur);
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/bcd_digit_reg.sv
// Module: the digit state register. ASYNC_CLEAR selects a clear that acts
// without a clock, or one sampled on the rising edge. Either way, reset
// overrides the incoming next value.
module bcd_digit_reg
    import bcd_stage_pkg::*;
#(
    parameter bit ASYNC_CLEAR = 1'b0
) (
    input  logic   clk,
    input  logic   rst_n,
    input  digit_t nxt,
    output digit_t q
);

    generate
        if (ASYNC_CLEAR) begin : g_async
            // Digit register with clear that acts at once.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= nxt;
            end

            // R5: while reset is low, the digit reads zero at any edge.
            assert_async_clear_R5: assert property (
                @(posedge clk) !rst_n |-> (q == '0)
            ) else $error("async clear did not hold digit at zero");
        end else begin : g_sync
            // Digit register with clear sampled on the edge.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= nxt;
            end

            // R6: a low reset sampled on an edge leaves zero after it.
            assert_sync_clear_R6: assert property (
                @(posedge clk) !rst_n |=> (q == '0)
            ) else $error("sync clear did not zero the digit");
        end
    endgenerate

endmodule

// File: rtl/bcd_carry_gen.sv
// Module: terminal-count flag. Combinational so the next stage's enable
// sees it in the same cycle; only the carry-chain enable gates it.
module bcd_carry_gen
    import bcd_stage_pkg::*;
(
    input  digit_t q,
    input  logic   carry_en,
    output logic   carry_out
);

    // Flag the last decimal code while the chain enable is high.
    always_comb carry_out = carry_en && (q == LAST_DIGIT);

endmodule

// File: rtl/bcd_decade_stage.sv
// Module: one cascadable BCD decade counter digit. Priority is reset, then
// load, then count (both enables), then hold. carry_out feeds the
// carry_en of the next stage for a fully synchronous chain.
module bcd_decade_stage
    import bcd_stage_pkg::*;
#(
    parameter bit ASYNC_CLEAR = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_n,
    input  logic               cnt_en,
    input  logic               carry_en,
    input  logic [DIGIT_W-1:0] din,
    output logic [DIGIT_W-1:0] q,
    output logic               carry_out
);

    stage_op_e op;
    digit_t    nxt;

    bcd_op_select u_sel (
        .load_n   (load_n),
        .cnt_en   (cnt_en),
        .carry_en (carry_en),
        .op       (op)
    );

    bcd_next_value u_nxt (
        .op  (op),
        .cur (q),
        .din (din),
        .nxt (nxt)
    );

    bcd_digit_reg #(.ASYNC_CLEAR(ASYNC_CLEAR)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt),
        .q     (q)
    );

    bcd_carry_gen u_carry (
        .q         (q),
        .carry_en  (carry_en),
        .carry_out (carry_out)
    );

    // R1: decimal codes below 9 advance by one when counting.
    assert_count_up_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en && carry_en && q < LAST_DIGIT) |=> (q == $past(q) + 4'd1)
    ) else $error("digit did not advance by one");

    // R1: the last decimal code wraps to zero.
    assert_count_wrap_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en && carry_en && q == LAST_DIGIT) |=> (q == '0)
    ) else $error("digit did not wrap to zero");

    // R2: a load copies din regardless of the enables.
    assert_load_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        !load_n |=> (q == $past(din))
    ) else $error("load did not capture din");

    // R3: without both enables and without load, the digit holds.
    assert_hold_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (load_n && !(cnt_en && carry_en)) |=> $stable(q)
    ) else $error("digit changed while not enabled");

    // R4: carry is never high without the chain enable.
    assert_carry_gate_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        carry_out |-> (carry_en && q == 4'd9)
    ) else $error("carry high outside last code with chain enable");

    // R7: odd non-decimal codes fold back into the decimal range.
    assert_fold_11_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en && carry_en && q == 4'd11) |=> (q == 4'd6)
    ) else $error("11 did not step to 6");

    assert_fold_13_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en && carry_en && q == 4'd13) |=> (q == 4'd4)
    ) else $error("13 did not step to 4");

    assert_fold_15_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en && carry_en && q == 4'd15) |=> (q == 4'd2)
    ) else $error("15 did not step to 2");

    // R7: even non-decimal codes step up by one.
    assert_even_step_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en && carry_en && (q == 4'd10 || q == 4'd12 || q == 4'd14))
        |=> (q == $past(q) + 4'd1)
    ) else $error("even non-decimal code did not step by one");

endmodule

// File: tb/bcd_decade_stage_tb_top.sv
// Bench: scoreboard for a sync-clear stage, direct checks for both clear
// styles, and a three-stage chain running through a full thousand-count cycle.
module bcd_decade_stage_tb_top;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // Main stage (synchronous clear) signals.
    logic       rst_n = 1'b0, load_n = 1'b1, cnt_en = 1'b0, carry_en = 1'b0;
    logic [3:0] din = '0;
    logic [3:0] q;
    logic       carry_out;

    bcd_decade_stage #(.ASYNC_CLEAR(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en(cnt_en),
        .carry_en(carry_en), .din(din), .q(q), .carry_out(carry_out)
    );

    // Asynchronous-clear stage sharing everything but its reset.
    logic       a_rst_n = 1'b0;
    logic [3:0] qa;
    logic       tca;

    bcd_decade_stage #(.ASYNC_CLEAR(1'b1)) dut_async_i (
        .clk(clk), .rst_n(a_rst_n), .load_n(load_n), .cnt_en(cnt_en),
        .carry_en(carry_en), .din(din), .q(qa), .carry_out(tca)
    );

    // Three-stage chain.
    logic       c_rst_n = 1'b0;
    logic [3:0] c0, c1, c2;
    logic       k0, k1, k2;

    bcd_decade_stage dut_c0 (.clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .cnt_en(1'b1),
        .carry_en(1'b1), .din(4'd0), .q(c0), .carry_out(k0));
    bcd_decade_stage dut_c1 (.clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .cnt_en(1'b1),
        .carry_en(k0), .din(4'd0), .q(c1), .carry_out(k1));
    bcd_decade_stage dut_c2 (.clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .cnt_en(1'b1),
        .carry_en(k1), .din(4'd0), .q(c2), .carry_out(k2));

    // Scoreboard queues: packed {tc, q} and the requirement tag.
    logic [4:0] sb_exp[$];
    string      sb_tag[$];
    logic [3:0] model_q = '0;

    function automatic logic [3:0] ref_step(input logic [3:0] v);
        if (v < 4'd9)       return v + 4'd1;
        else if (v == 4'd9) return 4'd0;
        else if (v == 4'd11) return 4'd6;
        else if (v == 4'd13) return 4'd4;
        else if (v == 4'd15) return 4'd2;
        else                return v + 4'd1;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of inputs and push the expected result.
    task automatic drive(input logic r, input logic ld, input logic ep,
                         input logic et, input logic [3:0] d, input string tag);
        @(negedge clk);
        rst_n = r; load_n = ld; cnt_en = ep; carry_en = et; din = d;
        if (!r)               model_q = 4'd0;
        else if (!ld)         model_q = d;
        else if (ep && et)    model_q = ref_step(model_q);
        sb_exp.push_back({(model_q == 4'd9) && et, model_q});
        sb_tag.push_back(tag);
    endtask

    // Monitor: compare after each edge against the oldest expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_exp.size() > 0) begin
                logic [4:0] e;
                string      t;
                e = sb_exp.pop_front();
                t = sb_tag.pop_front();
                checks++;
                if ({carry_out, q} !== e) begin
                    failures++;
                    $display("FAIL %s q=%0d tc=%0d expected q=%0d tc=%0d",
                             t, q, carry_out, e[3:0], e[4]);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int hi1, hi2;
        // Reset state (R6).
        drive(1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R6 reset state");
        drive(1'b0, 1'b1, 1'b1, 1'b1, 4'd0, "R6 reset holds against count");
        // Counting through a wrap (R1, R4).
        for (int i = 0; i < 12; i++) drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, "R1 R4 count");
        // Load ignores enables low (R2), then hold cases (R3, R4).
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd9, "R2 load with enables low");
        drive(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, "R3 R4 hold cnt_en low, carry high");
        drive(1'b1, 1'b1, 1'b0, 1'b1, 4'd3, "R3 R4 hold again");
        drive(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, "R3 R4 hold carry_en low, carry low");
        // Load wins over counting (R2).
        drive(1'b1, 1'b0, 1'b1, 1'b1, 4'd7, "R2 load over count");
        drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, "R1 count after load");
        // Non-decimal recovery (R7).
        for (int v = 10; v < 16; v++) begin
            drive(1'b1, 1'b0, 1'b0, 1'b0, 4'(v), "R2 load non-decimal");
            drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, "R7 recovery step");
        end
        drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, "R7 rejoined sequence");
        // Sync clear beats load (R6).
        drive(1'b0, 1'b0, 1'b1, 1'b1, 4'd5, "R6 clear over load");
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd4, "R2 load 4");
        while (sb_exp.size() > 0) @(posedge clk);
        #2;

        // Sync clear waits for the edge (R6).
        @(negedge clk);
        rst_n = 1'b0; load_n = 1'b0; din = 4'd6;
        #1 check("R6 no change before edge", q, 4);
        @(posedge clk); #1 check("R6 cleared at edge", q, 0);
        @(negedge clk);
        rst_n = 1'b1; load_n = 1'b1; cnt_en = 1'b1; carry_en = 1'b1;

        // Asynchronous clear stage (R5).
        a_rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1 check("R1 async variant counts", qa, 5);
        #1 a_rst_n = 1'b0;
        #1 check("R5 immediate clear", qa, 0);
        load_n = 1'b0; din = 4'd8;
        @(posedge clk); #1 check("R5 clear overrides load", qa, 0);
        @(negedge clk);
        load_n = 1'b1;

        // Three-stage chain (R8).
        @(negedge clk) c_rst_n = 1'b0;
        @(negedge clk) c_rst_n = 1'b1;
        check("R8 chain starts at 000", c2 * 100 + c1 * 10 + c0, 0);
        hi1 = 0; hi2 = 0;
        for (int i = 1; i <= 1000; i++) begin
            @(posedge clk); #1;
            check("R8 chain value", c2 * 100 + c1 * 10 + c0, i % 1000);
            check("R8 low carry", k0, int'(c0 == 4'd9));
            if (k1) hi1++;
            if (k2) hi2++;
        end
        check("R8 middle carry cycles", hi1, 10);
        check("R8 top carry cycles", hi2, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule